// File: doc/BRIEF.md
# Masked Address Window Translator

This block owns the configuration of a single outbound address window and translates local-bus accesses that land inside that window into a 64-bit target-bus address. Software programs four 32-bit registers through a small register port: a local base, a combined mask and attribute word, and the low and high halves of the target address. The window size comes from a mask of leading ones with a 4 KB granule. Address bits under a mask one are compared with the base and replaced by the target bits. Bits under a mask zero, and the 12 offset bits, pass straight through.

On the access side the block takes an address, a read flag and a burst-type code. It returns, combinationally, a hit flag, the translated address and a prefetch request. A prefetch request means the consumer should fetch 64 bytes ahead, and it is raised only for narrow reads into a window whose prefetch attribute is set. A mask whose ones do not form one unbroken run from the top is refused. The refused write sets a sticky configuration-error flag, which blocks hits until a legal mask is written.

Top module: `addr_window_xlate`

## Requirements
- R1: After reset every register reads as zero, and both `hit` and `cfg_err` are low.
- R2: Register index 0 is the local base, 1 the mask/attribute word, 2 the target low word and 3 the target high word. A write lands on the clock edge, and reads are combinational from `reg_addr`. The base register keeps only bits 31:12, and its bits 11:0 read as zero.
- R3: In the mask/attribute word, bits 31:12 are the mask, bit 1 is the prefetch enable and bit 0 is the window enable. Bits 11:2 always read as zero, whatever was written.
- R4: `hit` is high exactly when the enable bit is 1, `cfg_err` is 0, and `acc_addr` equals the base on every bit 31:12 whose mask bit is 1.
- R5: With the enable bit at 0, `hit` stays low for any address.
- R6: `tgt_addr[31:0]` takes the target-low bit where the mask bit is 1 and the access-address bit elsewhere, with bits 11:0 always from the access address. `tgt_addr[63:32]` equals the target-high register.
- R7: `pf_req` is high when `hit` is high, the prefetch bit is 1, `acc_rd` is 1 and `acc_burst` is 0 (single beat), 1 (byte burst) or 2 (halfword burst).
- R8: `pf_req` stays low for write accesses (`acc_rd` = 0) and for `acc_burst` = 3 (word or wider), even when prefetch is enabled.
- R9: A mask/attribute write whose mask field is not a run of ones from bit 31 followed only by zeros leaves that register unchanged. It sets `cfg_err`, which holds `hit` low until a later write with a legal mask clears it.
- R10: Mask 0xFFFFF gives a 4 KB window that compares all of bits 31:12. Mask 0xF8000 gives a 128 MB window that compares only bits 31:27. Mask 0 is legal and matches every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| acc_addr | input | 32 | Local access address |
| acc_rd | input | 1 | 1 = read access, 0 = write access |
| acc_burst | input | 2 | Burst type: 0 single, 1 byte, 2 halfword, 3 word or wider |
| hit | output | 1 | Access falls inside the enabled window |
| tgt_addr | output | 64 | Translated target address |
| pf_req | output | 1 | Request a 64-byte read prefetch |
| cfg_err | output | 1 | Sticky flag for a refused non-contiguous mask |

## Verification
The bench builds the block with its default parameters: a 32-bit local address and a 12-bit granule, which gives a 20-bit mask field. At that size, every legal mask from 0 to all ones can be stepped through in a loop. At each step, hitting and missing addresses are drawn just inside and just outside the window edge. The same size also makes the documented 4 KB and 128 MB encodings, and the refused non-contiguous patterns, direct register writes that the reference model can check bit for bit.

// File: rtl/awx_pkg.sv
// Shared definitions for the masked address window translator.
// Assumes the register index and burst code are both two bits wide.
package awx_pkg;

    // Register indices on the configuration port
    typedef enum logic [1:0] {
        REG_LBASE    = 2'd0,
        REG_MASKATTR = 2'd1,
        REG_TGTLO    = 2'd2,
        REG_TGTHI    = 2'd3
    } awx_reg_e;

    // Burst-type codes on the access side
    typedef enum logic [1:0] {
        BT_SINGLE = 2'd0,
        BT_BYTE   = 2'd1,
        BT_HALF   = 2'd2,
        BT_WIDE   = 2'd3
    } awx_burst_e;

    // Attribute bit positions inside the mask/attribute word
    localparam int ATTR_ENA_BIT = 0;
    localparam int ATTR_PRE_BIT = 1;

endpackage

// File: rtl/awx_regs.sv
// Configuration registers for one window: base, mask/attributes, target low/high.
// Refuses a mask that is not a single run of ones from the top bit and flags it
// with a sticky error. Assumes GRAN_LOG2 >= 3 so the attribute bits fit below it.
module awx_regs
    import awx_pkg::*;
#(
    parameter int LA_W      = 32,
    parameter int GRAN_LOG2 = 12,
    localparam int MW       = LA_W - GRAN_LOG2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [1:0]      addr,
    input  logic [LA_W-1:0] wdata,
    output logic [LA_W-1:0] rdata,
    output logic [MW-1:0]   base_q,
    output logic [MW-1:0]   mask_q,
    output logic            ena_q,
    output logic            pre_q,
    output logic [LA_W-1:0] tlo_q,
    output logic [LA_W-1:0] thi_q,
    output logic            cfg_err_q
);

    localparam logic [MW-1:0] ONE_M = MW'(1);

    awx_reg_e      sel;
    logic [MW-1:0] wmask;
    logic [MW-1:0] winv;
    logic          wlegal;

    assign sel = awx_reg_e'(addr);

    // Legal mask test: the inverted mask must be of the form 0..01..1
    always_comb begin
        wmask  = wdata[LA_W-1:GRAN_LOG2];
        winv   = ~wmask;
        wlegal = ((winv & (winv + ONE_M)) == '0);
    end

    // Register update on write, with mask refusal and sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            mask_q    <= '0;
            ena_q     <= 1'b0;
            pre_q     <= 1'b0;
            tlo_q     <= '0;
            thi_q     <= '0;
            cfg_err_q <= 1'b0;
        end else if (we) begin
            case (sel)
                REG_LBASE: base_q <= wmask;
                REG_MASKATTR: begin
                    if (wlegal) begin
                        mask_q    <= wmask;
                        ena_q     <= wdata[ATTR_ENA_BIT];
                        pre_q     <= wdata[ATTR_PRE_BIT];
                        cfg_err_q <= 1'b0;
                    end else begin
                        cfg_err_q <= 1'b1;
                    end
                end
                REG_TGTLO: tlo_q <= wdata;
                REG_TGTHI: thi_q <= wdata;
                default: ;
            endcase
        end
    end

    // Read mux; unused base bits and reserved attribute bits return zero
    always_comb begin
        case (sel)
            REG_LBASE:    rdata = {base_q, {GRAN_LOG2{1'b0}}};
            REG_MASKATTR: rdata = {mask_q, {(GRAN_LOG2-2){1'b0}}, pre_q, ena_q};
            REG_TGTLO:    rdata = tlo_q;
            REG_TGTHI:    rdata = thi_q;
            default:      rdata = '0;
        endcase
    end

endmodule

// File: rtl/awx_match.sv
// Window compare and address substitution. Purely combinational.
// Assumes the mask covers bits LA_W-1:GRAN_LOG2 and the offset bits always pass through.
module awx_match #(
    parameter int LA_W      = 32,
    parameter int GRAN_LOG2 = 12,
    localparam int MW       = LA_W - GRAN_LOG2
) (
    input  logic              ena,
    input  logic              cfg_err,
    input  logic [LA_W-1:0]   acc_addr,
    input  logic [MW-1:0]     base_q,
    input  logic [MW-1:0]     mask_q,
    input  logic [MW-1:0]     tlo_hi,
    input  logic [LA_W-1:0]   thi,
    output logic              hit,
    output logic [2*LA_W-1:0] tgt_addr
);

    logic [MW-1:0] diff;
    logic [MW-1:0] xl_hi;

    // One slice per maskable bit: mismatch detect and target/local select
    for (genvar g = 0; g < MW; g++) begin : g_bit
        assign diff[g]  = mask_q[g] & (acc_addr[GRAN_LOG2+g] ^ base_q[g]);
        assign xl_hi[g] = mask_q[g] ? tlo_hi[g] : acc_addr[GRAN_LOG2+g];
    end

    // Hit needs enable, no pending error and no masked mismatch
    assign hit      = ena & ~cfg_err & ~(|diff);
    assign tgt_addr = {thi, xl_hi, acc_addr[GRAN_LOG2-1:0]};

endmodule

// File: rtl/awx_prefetch.sv
// Prefetch qualifier: asks for a 64-byte read-ahead on narrow reads that hit.
// Assumes the burst code follows awx_burst_e.
module awx_prefetch
    import awx_pkg::*;
(
    input  logic       hit,
    input  logic       pre_en,
    input  logic       acc_rd,
    input  logic [1:0] acc_burst,
    output logic       pf_req
);

    awx_burst_e burst;
    logic       narrow;

    assign burst = awx_burst_e'(acc_burst);

    // Classify the burst type as narrow or wide
    always_comb begin
        case (burst)
            BT_SINGLE, BT_BYTE, BT_HALF: narrow = 1'b1;
            default:                     narrow = 1'b0;
        endcase
    end

    assign pf_req = hit & pre_en & acc_rd & narrow;

endmodule

// File: rtl/addr_window_xlate.sv
// Top of the masked address window translator: register block, window
// matcher and prefetch qualifier. The access path is combinational; only
// register writes are clocked. Assumes software programs base and target
// before setting the enable bit.
module addr_window_xlate #(
    parameter int LA_W      = 32,
    parameter int GRAN_LOG2 = 12,
    localparam int MW       = LA_W - GRAN_LOG2,
    localparam int TGT_W    = 2 * LA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [LA_W-1:0]  reg_wdata,
    output logic [LA_W-1:0]  reg_rdata,
    input  logic [LA_W-1:0]  acc_addr,
    input  logic             acc_rd,
    input  logic [1:0]       acc_burst,
    output logic             hit,
    output logic [TGT_W-1:0] tgt_addr,
    output logic             pf_req,
    output logic             cfg_err
);

    logic [MW-1:0]   base_w;
    logic [MW-1:0]   mask_w;
    logic            ena_w;
    logic            pre_w;
    logic [LA_W-1:0] tlo_w;
    logic [LA_W-1:0] thi_w;

    awx_regs #(.LA_W(LA_W), .GRAN_LOG2(GRAN_LOG2)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .base_q    (base_w),
        .mask_q    (mask_w),
        .ena_q     (ena_w),
        .pre_q     (pre_w),
        .tlo_q     (tlo_w),
        .thi_q     (thi_w),
        .cfg_err_q (cfg_err)
    );

    awx_match #(.LA_W(LA_W), .GRAN_LOG2(GRAN_LOG2)) u_match (
        .ena      (ena_w),
        .cfg_err  (cfg_err),
        .acc_addr (acc_addr),
        .base_q   (base_w),
        .mask_q   (mask_w),
        .tlo_hi   (tlo_w[LA_W-1:GRAN_LOG2]),
        .thi      (thi_w),
        .hit      (hit),
        .tgt_addr (tgt_addr)
    );

    awx_prefetch u_pf (
        .hit       (hit),
        .pre_en    (pre_w),
        .acc_rd    (acc_rd),
        .acc_burst (acc_burst),
        .pf_req    (pf_req)
    );

endmodule

// File: rtl/awx_checker.sv
// Property checker for addr_window_xlate, attached with bind below.
// Assumes the bench holds rst_n low from time zero.
module awx_checker #(
    parameter int LA_W      = 32,
    parameter int GRAN_LOG2 = 12,
    localparam int MW       = LA_W - GRAN_LOG2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_we,
    input logic [1:0]           reg_addr,
    input logic [MW-1:0]        wr_mask,
    input logic [GRAN_LOG2-1:2] rd_rsv,
    input logic [GRAN_LOG2-1:0] acc_off,
    input logic                 acc_rd,
    input logic [1:0]           acc_burst,
    input logic                 hit,
    input logic [GRAN_LOG2-1:0] tgt_off,
    input logic                 pf_req,
    input logic                 cfg_err,
    input logic                 ena,
    input logic [MW-1:0]        mask_q
);

    logic wr_legal;
    logic seen_zero;

    // Independent contiguity scan of the mask being written
    always_comb begin
        wr_legal  = 1'b1;
        seen_zero = 1'b0;
        for (int i = MW - 1; i >= 0; i--) begin
            if (!wr_mask[i]) seen_zero = 1'b1;
            else if (seen_zero) wr_legal = 1'b0;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> (!hit && !cfg_err)); // R1
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (reg_addr == 2'd1) |-> (rd_rsv == '0)); // R3
    AST_NO_HIT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) !ena |-> !hit); // R5
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n) tgt_off == acc_off); // R6
    AST_PF_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n) pf_req |-> (hit && acc_rd)); // R7
    AST_NO_PF_WIDE: assert property (@(posedge clk) disable iff (!rst_n) (!acc_rd || acc_burst == 2'd3) |-> !pf_req); // R8
    AST_BAD_MASK_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (reg_we && reg_addr == 2'd1 && !wr_legal) |=> (cfg_err && mask_q == $past(mask_q))); // R9
    AST_GOOD_MASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (reg_we && reg_addr == 2'd1 && wr_legal) |=> !cfg_err); // R9
    AST_NO_HIT_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n) cfg_err |-> !hit); // R9

endmodule

bind addr_window_xlate awx_checker #(.LA_W(LA_W), .GRAN_LOG2(GRAN_LOG2)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .wr_mask   (reg_wdata[LA_W-1:GRAN_LOG2]),
    .rd_rsv    (reg_rdata[GRAN_LOG2-1:2]),
    .acc_off   (acc_addr[GRAN_LOG2-1:0]),
    .acc_rd    (acc_rd),
    .acc_burst (acc_burst),
    .hit       (hit),
    .tgt_off   (tgt_addr[GRAN_LOG2-1:0]),
    .pf_req    (pf_req),
    .cfg_err   (cfg_err),
    .ena       (ena_w),
    .mask_q    (mask_w)
);

// File: tb/addr_window_xlate_tb_top.sv
// Bench for addr_window_xlate: a behavioural reference model updated on every
// rising edge and compared against all outputs at every falling edge.
module addr_window_xlate_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [31:0] acc_addr = 32'd0;
    logic        acc_rd = 1'b1;
    logic [1:0]  acc_burst = 2'd0;
    logic        hit;
    logic [63:0] tgt_addr;
    logic        pf_req;
    logic        cfg_err;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    started = 1'b0;
    bit    done = 1'b0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    // Reference model state
    logic [31:0] m_base = '0, m_ma = '0, m_tlo = '0, m_thi = '0;
    bit          m_err = 1'b0;

    always #5 clk = ~clk;

    addr_window_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_addr(acc_addr),
        .acc_rd(acc_rd), .acc_burst(acc_burst), .hit(hit), .tgt_addr(tgt_addr),
        .pf_req(pf_req), .cfg_err(cfg_err)
    );

    function automatic bit legal_mask(logic [31:0] w);
        bit seen0 = 1'b0;
        for (int i = 31; i >= 12; i--) begin
            if (!w[i]) seen0 = 1'b1;
            else if (seen0) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic bit exp_hit(logic [31:0] a);
        for (int i = 12; i < 32; i++)
            if (m_ma[i] && (a[i] != m_base[i])) return 1'b0;
        return m_ma[0] && !m_err;
    endfunction

    function automatic logic [63:0] exp_tgt(logic [31:0] a);
        logic [63:0] r;
        r[63:32] = m_thi;
        for (int i = 0; i < 32; i++)
            r[i] = (i >= 12 && m_ma[i]) ? m_tlo[i] : a[i];
        return r;
    endfunction

    function automatic logic [31:0] exp_rd(logic [1:0] idx);
        case (idx)
            2'd0: return m_base;
            2'd1: return m_ma;
            2'd2: return m_tlo;
            default: return m_thi;
        endcase
    endfunction

    // Model update on the same edge the design registers writes
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_base <= '0; m_ma <= '0; m_tlo <= '0; m_thi <= '0; m_err <= 1'b0;
        end else if (reg_we) begin
            case (reg_addr)
                2'd0: m_base <= reg_wdata & 32'hFFFF_F000;
                2'd1: if (legal_mask(reg_wdata)) begin
                          m_ma <= reg_wdata & 32'hFFFF_F003;
                          m_err <= 1'b0;
                      end else m_err <= 1'b1;
                2'd2: m_tlo <= reg_wdata;
                default: m_thi <= reg_wdata;
            endcase
        end
    end

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    // Compare every output mid-cycle
    always @(negedge clk) begin
        if (started && !done) begin
            bit eh;
            eh = exp_hit(acc_addr);
            chk("rdata", 64'(reg_rdata), 64'(exp_rd(reg_addr)));
            chk("hit", 64'(hit), 64'(eh));
            chk("tgt_addr", tgt_addr, exp_tgt(acc_addr));
            chk("pf_req", 64'(pf_req),
                64'(eh && m_ma[1] && acc_rd && acc_burst != 2'd3));
            chk("cfg_err", 64'(cfg_err), 64'(m_err));
        end
    end

    task automatic wr(logic [1:0] idx, logic [31:0] d);
        @(posedge clk); #2;
        reg_we = 1'b1; reg_addr = idx; reg_wdata = d;
    endtask

    task automatic rd(logic [1:0] idx);
        @(posedge clk); #2;
        reg_we = 1'b0; reg_addr = idx;
    endtask

    task automatic acc(logic [31:0] a, logic r, logic [1:0] b);
        @(posedge clk); #2;
        reg_we = 1'b0; acc_addr = a; acc_rd = r; acc_burst = b;
    endtask

    function automatic logic [31:0] next_rnd(logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog: a hung run is a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        cur_req = "R1";  // reset values of every register and output
        for (int i = 0; i < 4; i++) rd(2'(i));
        acc(32'h0000_0000, 1'b1, 2'd0);

        cur_req = "R2";  // register map and base low bits reading zero
        wr(2'd0, 32'h1234_5ABC);
        wr(2'd2, 32'hDEAD_BEEF);
        wr(2'd3, 32'h0000_00A5);
        rd(2'd0); rd(2'd2); rd(2'd3);

        cur_req = "R3";  // reserved bits forced to zero on readback
        wr(2'd1, 32'hF800_0FFF);
        rd(2'd1);

        cur_req = "R10"; // 128 MB window, then 4 KB window
        acc(32'h1000_0000, 1'b1, 2'd3);
        acc(32'h17FF_FFFF, 1'b1, 2'd0);
        acc(32'h1800_0000, 1'b1, 2'd0);
        acc(32'h0FFF_FFFF, 1'b1, 2'd0);
        wr(2'd1, 32'hFFFF_F001);
        acc(32'h1234_5FFF, 1'b1, 2'd0);
        acc(32'h1234_4FFF, 1'b1, 2'd0);
        acc(32'h1234_6000, 1'b1, 2'd0);
        wr(2'd1, 32'h0000_0001);
        acc(32'hCAFE_0123, 1'b0, 2'd1);

        cur_req = "R4";  // every legal mask size, hitting and missing
        for (int k = 0; k <= 20; k++) begin
            logic [31:0] mf;
            mf = (32'hFFFF_FFFF << (12 + k));
            if (k == 20) mf = 32'h0;
            wr(2'd1, mf | 32'h3);
            for (int j = 0; j < 4; j++) begin
                lfsr = next_rnd(lfsr);
                if (j[0]) acc((32'h1234_5000 & mf) | (lfsr & ~mf), lfsr[0], lfsr[2:1]);
                else acc(lfsr, lfsr[0], lfsr[2:1]);
            end
        end

        cur_req = "R6";  // target high change and substitution
        wr(2'd3, 32'h8000_0001);
        wr(2'd2, 32'h5A5A_5A5A);
        wr(2'd1, 32'hFFC0_0001);
        acc(32'h1237_FFFF, 1'b1, 2'd0);
        acc(32'h1200_0ABC, 1'b0, 2'd3);

        cur_req = "R7";  // narrow reads request prefetch
        wr(2'd1, 32'hFF00_0003);
        for (int b = 0; b < 3; b++) acc(32'h1211_2233, 1'b1, 2'(b));

        cur_req = "R8";  // wide reads and all writes never prefetch
        acc(32'h1211_2233, 1'b1, 2'd3);
        for (int b = 0; b < 4; b++) acc(32'h1211_2233, 1'b0, 2'(b));

        cur_req = "R5";  // disabled window never hits
        wr(2'd1, 32'hFF00_0002);
        acc(32'h1211_2233, 1'b1, 2'd0);
        acc(32'h12FF_FFFF, 1'b1, 2'd1);

        cur_req = "R9";  // refused mask, sticky error, recovery
        wr(2'd1, 32'hFF00_0003);
        wr(2'd1, 32'hF0F0_0003);
        rd(2'd1);
        acc(32'h1211_2233, 1'b1, 2'd0);
        wr(2'd2, 32'h0BAD_0000);
        acc(32'h1211_2233, 1'b1, 2'd0);
        wr(2'd1, 32'h8000_1003);
        acc(32'h1211_2233, 1'b1, 2'd0);
        wr(2'd1, 32'hFFF0_0003);
        rd(2'd1);
        acc(32'h1211_2233, 1'b1, 2'd0);

        @(posedge clk); #2;
        @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule